// File: doc/BRIEF.md
# Lockable Watchdog with Reset Pulse Output

This block is a supervisory timer for a small 8-bit controller. The CPU cannot read it. It sees only byte writes on the controller's register-write port that target one write-only service address. A correct two-byte key written to that address turns the timer on. The same key, written again later, restarts the count. Once the timer is on, software has no way to turn it off. Only a hardware reset, or the timer's own expiry, returns it to the off state.

While it is on, a counter advances on each machine-cycle strobe. If software fails to service it in time, the counter reaches its all-ones value. The block then raises an internal device-reset request for a fixed number of oscillator clocks and drives the external reset pin high for the same span. A mask input can suppress the pin drive. In power-down the count is frozen. After a wake-up caused by the external interrupt, the count stays held until the interrupt line has gone high again.

Top module: `wdog_top`

## Requirements
- R1: After hardware reset the timer is off: `dev_rst_req` and `rst_out` are low, and no expiry occurs however long the strobe runs.
- R2: Writing 0x1E and then 0xE1 to address 0xA6 turns the timer on. Writes to any other address in between are ignored and do not break the key.
- R3: A write to 0xA6 that breaks the order (anything other than 0xE1 after 0x1E) discards the partial key without any effect. A following 0x1E starts a fresh key.
- R4: Once the timer is on, no sequence of writes turns it off. Broken keys do not alter the running count.
- R5: The counter advances once per machine-cycle strobe. `dev_rst_req` rises on the clock after the strobe that brings the count to all ones, i.e. 2^CNT_W−1 strobes after the last service.
- R6: The key written while the timer is on restarts the count from zero.
- R7: `dev_rst_req` stays high for exactly PULSE_LEN (98) oscillator clocks.
- R8: With `rsto_dis` high, `rst_out` stays low during an expiry while `dev_rst_req` still pulses. With `rsto_dis` low, `rst_out` follows `dev_rst_req`.
- R9: An expiry turns the timer off. No second expiry follows unless the key is written again.
- R10: While `pd_mode` is high, strobes do not advance the count.
- R11: If `irq_n` is low during power-down, counting stays held after `pd_mode` falls, until `irq_n` goes high.
- R12: A hardware reset while the timer runs turns it off and discards the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_hw | input | 1 | Hardware reset, active high, asynchronous |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| pd_mode | input | 1 | Power-down indication |
| irq_n | input | 1 | External interrupt level, active low |
| rsto_dis | input | 1 | Masks the reset pin drive when high |
| rst_out | output | 1 | Reset pin drive, high during expiry |
| dev_rst_req | output | 1 | Internal device-reset request |

## Verification
The hardest state to reach is a running count that sits held after an interrupt wake. It needs the timer on, power-down entered with the interrupt already low, power-down left while the interrupt stays low, and a long wait before the line is released. The bench reaches it by driving every control change at a fixed phase of its own machine-cycle divider. It counts only the strobes that the requirements say should advance the count. The expiry must then arrive exactly 2^CNT_W−1 counted strobes after the last service. A single lost or extra strobe during the hold shows up as a count mismatch.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam logic [7:0] WD_ADDR_DEF = 8'hA6;
   localparam logic [7:0] WD_KEY_FIRST = 8'h1E;
   localparam logic [7:0] WD_KEY_SECOND = 8'hE1;
   typedef enum logic [0:0] {KEY_IDLE, KEY_ARMED} key_state_t;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock #(
   parameter int AW = 8,
   parameter int DW = 8,
   parameter logic [AW-1:0] SVC_ADDR = wdog_pkg::WD_ADDR_DEF,
   parameter logic [DW-1:0] KEY_A = wdog_pkg::WD_KEY_FIRST,
   parameter logic [DW-1:0] KEY_B = wdog_pkg::WD_KEY_SECOND
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr_i,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          svc_o
);
   import wdog_pkg::*;

   initial assert (KEY_A != KEY_B) else $error("wdog_unlock: keys must differ");

   key_state_t state_q;
   logic       hit;

   assign hit = wr_en && (wr_addr == SVC_ADDR);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state_q <= KEY_IDLE;
         svc_o   <= 1'b0;
      end else begin
         svc_o <= 1'b0;
         if (clr_i) begin
            state_q <= KEY_IDLE;
         end else if (hit) begin
            if (state_q == KEY_ARMED && wr_data == KEY_B) begin
               svc_o   <= 1'b1;
               state_q <= KEY_IDLE;
            end else if (wr_data == KEY_A) begin
               state_q <= KEY_ARMED;
            end else begin
               state_q <= KEY_IDLE;
            end
         end
      end
   end

   // R2: a service pulse only ever follows a second-key write to the service address
   assert_svc_after_key_R2: assert property (@(posedge clk) disable iff (rst)
      svc_o |-> $past(wr_en && wr_addr == SVC_ADDR && wr_data == KEY_B));
endmodule

// File: rtl/wdog_wake_hold.sv
module wdog_wake_hold (
   input  logic clk,
   input  logic rst,
   input  logic pd_i,
   input  logic irq_n_i,
   output logic run_o
);
   logic hold_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) hold_q <= 1'b0;
      else if (pd_i && !irq_n_i) hold_q <= 1'b1;
      else if (!pd_i && irq_n_i) hold_q <= 1'b0;
   end

   assign run_o = !pd_i && !hold_q;

   // R11: the hold is released only once the interrupt line is high
   assert_hold_release_R11: assert property (@(posedge clk) disable iff (rst)
      $fell(hold_q) |-> $past(irq_n_i));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 14
) (
   input  logic clk,
   input  logic rst,
   input  logic clr_i,
   input  logic svc_i,
   input  logic tick_i,
   input  logic run_i,
   output logic en_o,
   output logic ovf_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   initial assert (CNT_W >= 2 && CNT_W <= 32) else $error("wdog_counter: CNT_W out of range");

   logic             en_q;
   logic [CNT_W-1:0] cnt_q;
   logic             adv;

   assign adv = en_q && tick_i && run_i && (cnt_q != CNT_MAX);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         en_q  <= 1'b0;
         cnt_q <= '0;
      end else if (clr_i) begin
         en_q  <= 1'b0;
         cnt_q <= '0;
      end else if (svc_i) begin
         en_q  <= 1'b1;
         cnt_q <= '0;
      end else if (adv) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign en_o  = en_q;
   assign ovf_o = en_q && (cnt_q == CNT_MAX);

   // R4: enable drops only through the expiry reset
   assert_no_soft_disable_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(en_q) |-> $past(clr_i));
   // R5: a qualified strobe advances the count by one
   assert_step_R5: assert property (@(posedge clk) disable iff (rst)
      (en_q && tick_i && run_i && !clr_i && !svc_i && !ovf_o) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
   // R10: without the run gate the count holds
   assert_frozen_R10: assert property (@(posedge clk) disable iff (rst)
      (!run_i && !svc_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int PULSE_LEN = 98
) (
   input  logic clk,
   input  logic rst,
   input  logic ovf_i,
   output logic req_o
);
   localparam int PW = $clog2(PULSE_LEN + 1);

   initial assert (PULSE_LEN >= 2) else $error("wdog_pulse: PULSE_LEN too small");

   logic [PW-1:0] pcnt_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) pcnt_q <= '0;
      else if (pcnt_q != '0) pcnt_q <= pcnt_q - PW'(1);
      else if (ovf_i) pcnt_q <= PW'(PULSE_LEN);
   end

   assign req_o = (pcnt_q != '0);

   // R5: the request starts only on an expiry
   assert_start_on_ovf_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(req_o) |-> $past(ovf_i));
endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
   parameter int AW = 8,
   parameter int DW = 8,
   parameter logic [AW-1:0] SVC_ADDR = wdog_pkg::WD_ADDR_DEF,
   parameter int CNT_W = 14,
   parameter int PULSE_LEN = 98,
   parameter bit WAKE_HOLD = 1'b1
) (
   input  logic          clk_osc,
   input  logic          rst_hw,
   input  logic          mc_tick,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          pd_mode,
   input  logic          irq_n,
   input  logic          rsto_dis,
   output logic          rst_out,
   output logic          dev_rst_req
);
   initial assert (AW >= 1 && DW >= 8) else $error("wdog_top: bus too narrow");

   logic svc;
   logic run;
   logic cnt_en;
   logic ovf;
   logic req;

   wdog_unlock #(.AW(AW), .DW(DW), .SVC_ADDR(SVC_ADDR),
                 .KEY_A(DW'(wdog_pkg::WD_KEY_FIRST)), .KEY_B(DW'(wdog_pkg::WD_KEY_SECOND)))
   u_unlock (
      .clk(clk_osc), .rst(rst_hw), .clr_i(req),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .svc_o(svc));

   generate
      if (WAKE_HOLD) begin : g_hold
         wdog_wake_hold u_hold (
            .clk(clk_osc), .rst(rst_hw), .pd_i(pd_mode), .irq_n_i(irq_n), .run_o(run));
      end else begin : g_nohold
         logic unused_irq;
         assign unused_irq = irq_n;
         assign run = !pd_mode;
      end
   endgenerate

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk_osc), .rst(rst_hw), .clr_i(req), .svc_i(svc),
      .tick_i(mc_tick), .run_i(run), .en_o(cnt_en), .ovf_o(ovf));

   wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk(clk_osc), .rst(rst_hw), .ovf_i(ovf), .req_o(req));

   assign dev_rst_req = req;
   assign rst_out     = req && !rsto_dis;

   // R1: no reset request unless the timer was on
   assert_only_when_on_R1: assert property (@(posedge clk_osc) disable iff (rst_hw)
      $rose(dev_rst_req) |-> $past(cnt_en));
   // R9: the request is never seen while the timer is still on a cycle later
   assert_off_after_expiry_R9: assert property (@(posedge clk_osc) disable iff (rst_hw)
      $rose(dev_rst_req) |=> !cnt_en);
endmodule

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
   localparam int CW = 8;
   localparam int PL = 98;
   localparam int FULL = (1 << CW) - 1;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_hw = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = 8'h00;
   logic [7:0] wr_data = 8'h00;
   logic       pd_mode = 1'b0;
   logic       irq_n = 1'b1;
   logic       rsto_dis = 1'b0;
   logic       rst_out;
   logic       dev_rst_req;
   logic       mc_tick;

   int  div = 0;
   int  tick_total = 0;
   int  base = 0;
   bit  exp_run = 1'b1;
   int  n_run = 0;
   int  n_fail = 0;

   always @(posedge clk) div <= (div == 11) ? 0 : div + 1;
   assign mc_tick = (div == 0);
   always @(posedge clk) if (mc_tick && exp_run) tick_total = tick_total + 1;

   wdog_top #(.CNT_W(CW), .PULSE_LEN(PL)) u0 (
      .clk_osc(clk), .rst_hw(rst_hw), .mc_tick(mc_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pd_mode(pd_mode), .irq_n(irq_n),
      .rsto_dis(rsto_dis), .rst_out(rst_out), .dev_rst_req(dev_rst_req));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic phase5();
      do @(negedge clk); while (div != 5);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      phase5();
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // second key write; the expected count restarts here
   task automatic key_tail();
      phase5();
      wr_en = 1'b1; wr_addr = 8'hA6; wr_data = 8'hE1;
      base = tick_total;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic service();
      wr(8'hA6, 8'h1E);
      key_tail();
   endtask

   task automatic wait_ticks(input int n);
      repeat (n * 12) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_hw = 1'b1; pd_mode = 1'b0; irq_n = 1'b1; exp_run = 1'b1;
      repeat (3) @(negedge clk);
      rst_hw = 1'b0;
   endtask

   task automatic expect_expiry(input string tag);
      int lim = (FULL + 40) * 12;
      int len = 0;
      int bad_pin = 0;
      while (!dev_rst_req && lim > 0) begin @(negedge clk); lim--; end
      chk(dev_rst_req == 1'b1, {tag, " R5 expiry seen"}, dev_rst_req, 1);
      chk(tick_total - base == FULL, {tag, " R5 strobes to expiry"}, tick_total - base, FULL);
      while (dev_rst_req && len < PL + 20) begin
         if (rst_out != !rsto_dis) bad_pin++;
         len++;
         @(negedge clk);
      end
      chk(len == PL, {tag, " R7 pulse length"}, len, PL);
      chk(bad_pin == 0, {tag, " R8 pin vs mask"}, bad_pin, 0);
   endtask

   task automatic expect_quiet(input int n, input string tag);
      int seen = 0;
      repeat (n * 12) begin
         @(negedge clk);
         if (dev_rst_req || rst_out) seen++;
      end
      chk(seen == 0, tag, seen, 0);
   endtask

   task automatic t_reset();
      do_reset();
      chk(dev_rst_req == 1'b0 && rst_out == 1'b0, "R1 outputs low after reset", dev_rst_req, 0);
      expect_quiet(FULL + 45, "R1 no expiry while off");
   endtask

   task automatic t_enable();
      do_reset();
      wr(8'hA6, 8'h1E);
      wr(8'h80, 8'hE1);          // other address: ignored (R2)
      key_tail();
      expect_expiry("R2 enable");
      expect_quiet(FULL + 45, "R9 off after expiry");
   endtask

   task automatic t_broken();
      do_reset();
      wr(8'hA6, 8'h1E);
      wr(8'hA6, 8'h55);
      wr(8'hA6, 8'hE1);
      expect_quiet(FULL + 45, "R3 broken key discarded");
      wr(8'hA6, 8'h1E);
      wr(8'hA6, 8'h1E);
      key_tail();
      expect_expiry("R3 fresh key");
   endtask

   task automatic t_lock();
      do_reset();
      service();
      wait_ticks(50);
      wr(8'hA6, 8'h00);
      wr(8'hA6, 8'h1E);
      wr(8'hA6, 8'hFF);
      wr(8'hA6, 8'hE1);
      expect_expiry("R4 writes cannot disable");
   endtask

   task automatic t_restart();
      do_reset();
      service();
      wait_ticks(200);
      chk(dev_rst_req == 1'b0, "R6 no expiry before restart", dev_rst_req, 0);
      service();
      expect_expiry("R6 restart");
   endtask

   task automatic t_mask();
      do_reset();
      rsto_dis = 1'b1;
      service();
      expect_expiry("R8 masked pin");
      rsto_dis = 1'b0;
   endtask

   task automatic t_pd();
      do_reset();
      service();
      wait_ticks(100);
      phase5(); pd_mode = 1'b1; exp_run = 1'b0;
      expect_quiet(FULL + 45, "R10 frozen in power-down");
      phase5(); pd_mode = 1'b0; exp_run = 1'b1;
      expect_expiry("R10 resume");
   endtask

   task automatic t_wake();
      do_reset();
      service();
      wait_ticks(50);
      phase5(); pd_mode = 1'b1; irq_n = 1'b0; exp_run = 1'b0;
      wait_ticks(20);
      phase5(); pd_mode = 1'b0;
      expect_quiet(FULL, "R11 held while irq low");
      phase5(); irq_n = 1'b1; exp_run = 1'b1;
      expect_expiry("R11 after wake");
   endtask

   task automatic t_hwreset();
      do_reset();
      service();
      wait_ticks(100);
      do_reset();
      expect_quiet(FULL + 45, "R12 hardware reset stops timer");
   endtask

   initial begin
      #(4 * 200000);
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_enable();
      t_broken();
      t_lock();
      t_restart();
      t_mask();
      t_pd();
      t_wake();
      t_hwreset();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule